// File: doc/BRIEF.md
# Picture-in-Picture Inset Window Controller

This block produces the timing that places a reduced sub-picture inside the main picture. It runs on the 4x colour-subcarrier pixel clock (about 14.32 MHz). It counts pixels from the rising edge of the main horizontal sync and counts lines from the active-high vertical sync. From these counts it decides, for every pixel, whether that pixel lies inside the inset, on its border, or in the main picture.

Inside the inset, the block issues read addresses to the sub-picture field store. The store is an external synchronous RAM with a one-cycle read latency. The block returns the stored 6-bit luma sample on its inset luma output. It also drives a switch output that selects inset video over main video. The field store is loaded through a write path that the block passes on. A freeze control blocks that path, so the stored picture stays on screen unchanged.

The inset settings are size, corner, border on/off, border luma and freeze. They are all sampled once per field, on the vertical sync rising edge.

Top module: `pip_inset_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the switch output, the inset luma, the store write enable and the store read enable are all 0.
- R2: A line starts at a rising edge of horizontal sync. Pixel index 0 is the cycle after the first cycle in which horizontal sync reads high. The outputs for pixel index x appear 3 cycles after that pixel's cycle, and the read request for it appears 1 cycle after.
- R3: After a vertical sync rising edge, the first following horizontal sync rising edge starts line 0. Each later horizontal sync rising edge advances the line by one.
- R4: Size bit 0 selects the one-ninth inset: PIX_NINTH samples by LINES_NINTH lines (171 by 69 by default). Size bit 1 selects the one-sixteenth inset: PIX_SIXTEENTH by LINES_SIXTEENTH (128 by 52). Corner bit 0 picks left (0) or right (1), and corner bit 1 picks top (0) or bottom (1). The left inset starts at pixel H_MARGIN. The right inset ends H_MARGIN pixels before pixel H_ACTIVE. The top inset starts at line V_MARGIN. The bottom inset ends V_MARGIN lines before line V_ACTIVE.
- R5: For each inset pixel the read enable is high and the read address is row*LINE_STRIDE + column. Row and column are counted from the inset's top-left corner. The value the store returns one cycle later is shown on the inset luma output with the switch high. Outside the inset the read enable is 0.
- R6: With the border enabled, pixels in a ring just outside the inset show the border luma level with the switch high. The ring is 2 pixels wide at the left and right and 1 line tall at the top and bottom, including its corners.
- R7: With the border disabled, border-ring pixels show as main picture: switch 0 and luma 0.
- R8: While display enable is low, the switch and the inset luma are 0. Read requests continue regardless.
- R9: Size, corner, border enable, border level and freeze are sampled only on a vertical sync rising edge. Changes at other times have no effect until the next one.
- R10: When not frozen, an incoming store write appears on the store write port one cycle later. When frozen, the store write enable stays 0.
- R11: Outside the inset and the enabled border, the switch is 0 and the inset luma is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | Main horizontal sync, rising edge used |
| vsync_i | input | 1 | Main vertical sync, active high |
| disp_en_i | input | 1 | Inset display enable |
| size16_i | input | 1 | 0: one-ninth inset, 1: one-sixteenth inset |
| corner_i | input | 2 | Bit 0 right, bit 1 bottom |
| frame_on_i | input | 1 | Border enable |
| frame_lvl_i | input | 6 | Border luma level |
| freeze_i | input | 1 | Block store writes |
| in_wr_en_i | input | 1 | Incoming store write strobe |
| in_wr_addr_i | input | AW | Incoming store write address |
| in_wr_data_i | input | 6 | Incoming store write sample |
| mem_wr_en_o | output | 1 | Store write enable |
| mem_wr_addr_o | output | AW | Store write address |
| mem_wr_data_o | output | 6 | Store write sample |
| mem_rd_en_o | output | 1 | Store read enable |
| mem_rd_addr_o | output | AW | Store read address |
| mem_rd_data_i | input | 6 | Store read sample, one cycle after the request |
| inset_sel_o | output | 1 | 1 selects inset video |
| inset_y_o | output | 6 | Inset luma, border level or 0 |

## Verification
The bench drives complete short fields that cover every corner and both sizes. It compares every cycle against a pixel model, so an off-by-one in the sync edge handling or in the margins shows up as a shifted window or a shifted border. It also turns the border off and disables display. A design that leaks the border or ignores display enable then shows non-zero luma where main video belongs. In the middle of each field, it flips every setting. A design that applies settings at once instead of at the field edge then moves the inset mid-field. Finally, it freezes the store and writes a new pattern. A design that does not gate writes then shows the new pattern and drives the write enable.

// File: rtl/pip_pkg.sv
package pip_pkg;

  localparam int unsigned SAMPLE_W = 6;

  typedef struct packed {
    logic                size16;
    logic [1:0]          corner;
    logic                frame_on;
    logic [SAMPLE_W-1:0] frame_lvl;
  } pip_cfg_t;

endpackage

// File: rtl/pip_sync_count.sv
module pip_sync_count #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  output logic [HW-1:0] hpos_o,
  output logic [VW-1:0] vpos_o,
  output logic          vs_rise_o
);

  localparam logic [HW-1:0] HMAX = '1;
  localparam logic [VW-1:0] VMAX = '1;

  logic hs_q, vs_q, v_first;
  logic hs_rise;

  assign hs_rise   = hsync_i & ~hs_q;
  assign vs_rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hpos_o  <= HMAX;
      vpos_o  <= '0;
      v_first <= 1'b1;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      // pixel counter restarts on each line start and parks at its top value
      if (hs_rise) hpos_o <= '0;
      else if (hpos_o != HMAX) hpos_o <= hpos_o + 1'b1;
      // the first line start after a field start is line 0
      if (vs_rise_o) begin
        vpos_o  <= '0;
        v_first <= 1'b1;
      end else if (hs_rise) begin
        if (v_first) v_first <= 1'b0;
        else if (vpos_o != VMAX) vpos_o <= vpos_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pip_window_map.sv
module pip_window_map import pip_pkg::*; #(
  parameter int H_ACTIVE        = 760,
  parameter int V_ACTIVE        = 242,
  parameter int H_MARGIN        = 48,
  parameter int V_MARGIN        = 20,
  parameter int PIX_NINTH       = 171,
  parameter int PIX_SIXTEENTH   = 128,
  parameter int LINES_NINTH     = 69,
  parameter int LINES_SIXTEENTH = 52,
  parameter int LINE_STRIDE     = 171,
  parameter int FRAME_PX        = 2,
  parameter int FRAME_LN        = 1,
  parameter int HW              = 11,
  parameter int VW              = 10,
  parameter int AW              = 14
) (
  input  logic [HW-1:0] hpos_i,
  input  logic [VW-1:0] vpos_i,
  input  pip_cfg_t      cfg_i,
  output logic          act_o,
  output logic          brd_o,
  output logic [AW-1:0] addr_o
);

  int hx, vy, w, l, x0, y0;
  logic in_h, in_v, ring_h, ring_v;

  always_comb begin
    hx = int'(hpos_i);
    vy = int'(vpos_i);
    w  = cfg_i.size16 ? PIX_SIXTEENTH   : PIX_NINTH;
    l  = cfg_i.size16 ? LINES_SIXTEENTH : LINES_NINTH;
    x0 = cfg_i.corner[0] ? (H_ACTIVE - H_MARGIN - w) : H_MARGIN;
    y0 = cfg_i.corner[1] ? (V_ACTIVE - V_MARGIN - l) : V_MARGIN;
    in_h   = (hx >= x0) && (hx < x0 + w);
    in_v   = (vy >= y0) && (vy < y0 + l);
    ring_h = (hx >= x0 - FRAME_PX) && (hx < x0 + w + FRAME_PX);
    ring_v = (vy >= y0 - FRAME_LN) && (vy < y0 + l + FRAME_LN);
    act_o  = in_h && in_v;
    brd_o  = ring_h && ring_v && !act_o;
    addr_o = act_o ? AW'((vy - y0) * LINE_STRIDE + (hx - x0)) : '0;
  end

endmodule

// File: rtl/pip_store_gate.sv
module pip_store_gate #(
  parameter int AW = 14,
  parameter int DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          vs_rise_i,
  input  logic          freeze_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          frz_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frz_o     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      if (vs_rise_i) frz_o <= freeze_i;
      wr_en_o   <= wr_en_i & ~frz_o;
      wr_addr_o <= wr_addr_i;
      wr_data_o <= wr_data_i;
    end
  end

endmodule

// File: rtl/pip_inset_ctrl.sv
module pip_inset_ctrl import pip_pkg::*; #(
  parameter int H_ACTIVE        = 760,
  parameter int V_ACTIVE        = 242,
  parameter int H_MARGIN        = 48,
  parameter int V_MARGIN        = 20,
  parameter int PIX_NINTH       = 171,
  parameter int PIX_SIXTEENTH   = 128,
  parameter int LINES_NINTH     = 69,
  parameter int LINES_SIXTEENTH = 52,
  parameter int LINE_STRIDE     = PIX_NINTH,
  parameter int FRAME_PX        = 2,
  parameter int FRAME_LN        = 1,
  localparam int AW             = $clog2(LINE_STRIDE * LINES_NINTH)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                disp_en_i,
  input  logic                size16_i,
  input  logic [1:0]          corner_i,
  input  logic                frame_on_i,
  input  logic [SAMPLE_W-1:0] frame_lvl_i,
  input  logic                freeze_i,
  input  logic                in_wr_en_i,
  input  logic [AW-1:0]       in_wr_addr_i,
  input  logic [SAMPLE_W-1:0] in_wr_data_i,
  output logic                mem_wr_en_o,
  output logic [AW-1:0]       mem_wr_addr_o,
  output logic [SAMPLE_W-1:0] mem_wr_data_o,
  output logic                mem_rd_en_o,
  output logic [AW-1:0]       mem_rd_addr_o,
  input  logic [SAMPLE_W-1:0] mem_rd_data_i,
  output logic                inset_sel_o,
  output logic [SAMPLE_W-1:0] inset_y_o
);

  localparam int HW = $clog2(H_ACTIVE + 1) + 1;
  localparam int VW = $clog2(V_ACTIVE + 1) + 1;

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          vs_rise;
  logic          frz_q;
  pip_cfg_t      cfg_q;
  logic          map_act, map_brd;
  logic [AW-1:0] map_addr;
  logic          a_act, a_brd, b_act, b_brd;

  pip_sync_count #(.HW(HW), .VW(VW)) u_cnt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .hpos_o   (hpos),
    .vpos_o   (vpos),
    .vs_rise_o(vs_rise)
  );

  pip_window_map #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .H_MARGIN(H_MARGIN), .V_MARGIN(V_MARGIN),
    .PIX_NINTH(PIX_NINTH), .PIX_SIXTEENTH(PIX_SIXTEENTH),
    .LINES_NINTH(LINES_NINTH), .LINES_SIXTEENTH(LINES_SIXTEENTH),
    .LINE_STRIDE(LINE_STRIDE), .FRAME_PX(FRAME_PX), .FRAME_LN(FRAME_LN),
    .HW(HW), .VW(VW), .AW(AW)
  ) u_map (
    .hpos_i(hpos),
    .vpos_i(vpos),
    .cfg_i (cfg_q),
    .act_o (map_act),
    .brd_o (map_brd),
    .addr_o(map_addr)
  );

  pip_store_gate #(.AW(AW), .DW(SAMPLE_W)) u_wr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .vs_rise_i(vs_rise),
    .freeze_i (freeze_i),
    .wr_en_i  (in_wr_en_i),
    .wr_addr_i(in_wr_addr_i),
    .wr_data_i(in_wr_data_i),
    .frz_o    (frz_q),
    .wr_en_o  (mem_wr_en_o),
    .wr_addr_o(mem_wr_addr_o),
    .wr_data_o(mem_wr_data_o)
  );

  // settings are taken once per field so the inset never tears mid-field
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
    end else if (vs_rise) begin
      cfg_q.size16    <= size16_i;
      cfg_q.corner    <= corner_i;
      cfg_q.frame_on  <= frame_on_i;
      cfg_q.frame_lvl <= frame_lvl_i;
    end
  end

  // stage A: read request; stage B: wait for store; stage C: output mux
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_act         <= 1'b0;
      a_brd         <= 1'b0;
      b_act         <= 1'b0;
      b_brd         <= 1'b0;
      mem_rd_en_o   <= 1'b0;
      mem_rd_addr_o <= '0;
      inset_sel_o   <= 1'b0;
      inset_y_o     <= '0;
    end else begin
      a_act       <= map_act;
      a_brd       <= map_brd;
      mem_rd_en_o <= map_act;
      if (map_act) mem_rd_addr_o <= map_addr;
      b_act <= a_act;
      b_brd <= a_brd;
      inset_sel_o <= disp_en_i & (b_act | (b_brd & cfg_q.frame_on));
      if (!disp_en_i)                  inset_y_o <= '0;
      else if (b_act)                  inset_y_o <= mem_rd_data_i;
      else if (b_brd && cfg_q.frame_on) inset_y_o <= cfg_q.frame_lvl;
      else                             inset_y_o <= '0;
    end
  end

endmodule

// File: rtl/pip_inset_checker.sv
module pip_inset_checker import pip_pkg::*; (
  input logic     clk_i,
  input logic     rst_i,
  input logic     disp_en_i,
  input logic     in_wr_en_i,
  input logic     vs_rise,
  input logic     frz_q,
  input pip_cfg_t cfg_q,
  input logic     mem_wr_en_o,
  input logic     mem_rd_en_o,
  input logic     inset_sel_o,
  input logic [SAMPLE_W-1:0] inset_y_o
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!inset_sel_o && !mem_wr_en_o && !mem_rd_en_o && inset_y_o == '0)); // R1

  AST_READ_SHOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_rd_en_o |=> ##1 (inset_sel_o || !$past(disp_en_i))); // R5

  AST_CFG_FIELD_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
    !vs_rise |=> $stable(cfg_q)); // R9

  AST_FROZEN_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_wr_en_i || frz_q) |=> !mem_wr_en_o); // R10

  AST_WRITE_PASSES: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_wr_en_i && !frz_q) |=> mem_wr_en_o); // R10

  AST_MAIN_LUMA_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !inset_sel_o |-> inset_y_o == '0); // R11

endmodule

bind pip_inset_ctrl pip_inset_checker u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .disp_en_i  (disp_en_i),
  .in_wr_en_i (in_wr_en_i),
  .vs_rise    (vs_rise),
  .frz_q      (frz_q),
  .cfg_q      (cfg_q),
  .mem_wr_en_o(mem_wr_en_o),
  .mem_rd_en_o(mem_rd_en_o),
  .inset_sel_o(inset_sel_o),
  .inset_y_o  (inset_y_o)
);

// File: tb/test_pip_inset_ctrl.sv
module test_pip_inset_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HA = 40, VA = 24, HM = 4, VM = 2;
  localparam int P9 = 12, P16 = 8, L9 = 6, L16 = 4;
  localparam int AW = 7, DEPTH = P9 * L9;
  localparam int LINE_LEN = 48, NFIELD = 7;

  // {size16, corner[1:0], frame_on, level[5:0], disp_en, freeze, seed[5:0]}
  localparam logic [17:0] FIELD_VEC [NFIELD] = '{
    {1'b0, 2'd0, 1'b1, 6'h3F, 1'b1, 1'b0, 6'd1},
    {1'b0, 2'd1, 1'b1, 6'h2A, 1'b1, 1'b0, 6'd7},
    {1'b1, 2'd2, 1'b0, 6'h15, 1'b1, 1'b0, 6'd3},
    {1'b1, 2'd3, 1'b1, 6'h30, 1'b1, 1'b0, 6'd9},
    {1'b0, 2'd3, 1'b1, 6'h11, 1'b0, 1'b0, 6'd2},
    {1'b0, 2'd0, 1'b1, 6'h22, 1'b1, 1'b1, 6'd12},
    {1'b1, 2'd1, 1'b1, 6'h05, 1'b1, 1'b0, 6'd20}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic hsync = 0, vsync = 0, disp_en = 0, size16 = 0, frame_on = 0, freeze = 0, in_wr_en = 0;
  logic [1:0] corner = 0;
  logic [5:0] frame_lvl = 0, in_wr_data = 0, rd_data;
  logic [AW-1:0] in_wr_addr = 0, mem_wr_addr, mem_rd_addr;
  logic [5:0] mem_wr_data, inset_y;
  logic mem_wr_en, mem_rd_en, inset_sel;

  logic [5:0] ram [DEPTH];
  logic [5:0] model_mem [DEPTH];

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model settings, latched when the bench drives a field start
  logic m_size16, m_frame, m_disp, m_frz;
  logic [1:0] m_corner;
  logic [5:0] m_lvl;

  logic h_sw [4];
  logic [5:0] h_y [4];
  logic h_rd [4];
  logic [AW-1:0] h_addr [4];
  string h_tag [4];
  logic wr_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pip_inset_ctrl #(
    .H_ACTIVE(HA), .V_ACTIVE(VA), .H_MARGIN(HM), .V_MARGIN(VM),
    .PIX_NINTH(P9), .PIX_SIXTEENTH(P16), .LINES_NINTH(L9), .LINES_SIXTEENTH(L16)
  ) i_pip_inset_ctrl (
    .clk_i(clk), .rst_i(rst), .hsync_i(hsync), .vsync_i(vsync), .disp_en_i(disp_en),
    .size16_i(size16), .corner_i(corner), .frame_on_i(frame_on), .frame_lvl_i(frame_lvl),
    .freeze_i(freeze), .in_wr_en_i(in_wr_en), .in_wr_addr_i(in_wr_addr),
    .in_wr_data_i(in_wr_data), .mem_wr_en_o(mem_wr_en), .mem_wr_addr_o(mem_wr_addr),
    .mem_wr_data_o(mem_wr_data), .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_data_i(rd_data), .inset_sel_o(inset_sel), .inset_y_o(inset_y)
  );

  // field store: synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en) rd_data <= ram[mem_rd_addr];
  end

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one clock cycle; x,y give the pixel position the counters hold in it (R2, R3)
  task automatic cycle(input bit v, input int x, input int y);
    int w, l, x0, y0;
    bit act, brd;
    logic e_sw;
    logic [5:0] e_y;
    string tag;
    w = m_size16 ? P16 : P9;
    l = m_size16 ? L16 : L9;
    x0 = m_corner[0] ? HA - HM - w : HM;   // R4
    y0 = m_corner[1] ? VA - VM - l : VM;
    act = v && x >= x0 && x < x0 + w && y >= y0 && y < y0 + l;
    brd = v && !act && x >= x0 - 2 && x < x0 + w + 2 && y >= y0 - 1 && y < y0 + l + 1;
    if (act) begin
      e_sw = 1; e_y = model_mem[(y - y0) * P9 + (x - x0)]; tag = "R4";
    end else if (brd && m_frame) begin
      e_sw = 1; e_y = m_lvl; tag = "R6";
    end else begin
      e_sw = 0; e_y = 0; tag = brd ? "R7" : "R11";
    end
    if (!m_disp && (act || brd)) begin e_sw = 0; e_y = 0; tag = "R8"; end
    @(negedge clk);
    for (int i = 3; i > 0; i--) begin
      h_sw[i] = h_sw[i-1]; h_y[i] = h_y[i-1]; h_rd[i] = h_rd[i-1];
      h_addr[i] = h_addr[i-1]; h_tag[i] = h_tag[i-1];
    end
    h_sw[0] = e_sw; h_y[0] = e_y; h_rd[0] = act; h_tag[0] = tag;
    h_addr[0] = act ? AW'((y - y0) * P9 + (x - x0)) : '0;
    check(h_tag[3], "switch", int'(inset_sel), int'(h_sw[3]));
    check(h_tag[3], "luma", int'(inset_y), int'(h_y[3]));
    check("R5", "read enable", int'(mem_rd_en), int'(h_rd[1]));
    if (h_rd[1]) check("R5", "read address", int'(mem_rd_addr), int'(h_addr[1]));
    check("R10", "write enable", int'(mem_wr_en), int'(wr_exp));
    wr_exp = in_wr_en && !m_frz;
    @(posedge clk); #1;
  endtask

  task automatic run_field(input int f);
    logic [17:0] v;
    v = FIELD_VEC[f];
    size16 = v[17]; corner = v[16:15]; frame_on = v[14]; frame_lvl = v[13:8];
    disp_en = v[7]; freeze = v[6];
    vsync = 1;
    cycle(0, 0, 0);
    vsync = 0;
    m_size16 = v[17]; m_corner = v[16:15]; m_frame = v[14]; m_lvl = v[13:8];
    m_disp = v[7]; m_frz = v[6];
    // reload the store; a frozen field must keep the old picture (R10)
    for (int a = 0; a < DEPTH; a++) begin
      in_wr_en = 1; in_wr_addr = AW'(a); in_wr_data = 6'((a * 5 + int'(v[5:0])) % 64);
      if (!m_frz) model_mem[a] = in_wr_data;
      cycle(0, 0, 0);
    end
    in_wr_en = 0;
    for (int k = 0; k < 4; k++) cycle(0, 0, 0);
    for (int ln = 0; ln < VA; ln++) begin
      for (int k = 0; k < LINE_LEN; k++) begin
        hsync = (k < 4);
        // R9: flip every setting mid-field; the window must not move
        if (ln == 8 && k == 0) begin
          size16 = ~size16; corner = ~corner; frame_on = ~frame_on;
          frame_lvl = ~frame_lvl; freeze = ~freeze;
        end
        cycle(k != 0, k - 1, ln);
      end
    end
    hsync = 0;
    for (int k = 0; k < 4; k++) cycle(0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      h_sw[i] = 0; h_y[i] = 0; h_rd[i] = 0; h_addr[i] = 0; h_tag[i] = "R11";
    end
    m_size16 = 0; m_corner = 0; m_frame = 0; m_lvl = 0; m_disp = 0; m_frz = 0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R1: quiet while in reset
    check("R1", "switch in reset", int'(inset_sel), 0);
    check("R1", "write enable in reset", int'(mem_wr_en), 0);
    @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    check("R1", "switch after reset", int'(inset_sel), 0);
    check("R1", "luma after reset", int'(inset_y), 0);
    check("R1", "read enable after reset", int'(mem_rd_en), 0);
    @(posedge clk); #1;
    for (int f = 0; f < NFIELD; f++) run_field(f);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule